// File: doc/BRIEF.md
# Cache Memory-Bus Burst Data Buffer

This block is the memory-side data slice of a cache data array. It keeps two cycle buffers, each holding a burst of four pieces. One buffer is active at a time. The active buffer feeds write pieces onto the memory data bus, or it collects read pieces from that bus. The CPU side fills either buffer through a load port and reads either buffer back through an unload port. The pad itself is not part of the block, so the bus appears as a separate input, an output and a drive-enable output.

A transfer step comes from a ready input in clocked mode. In strobed mode it comes from an output strobe while the block is writing, or from an input strobe while it is listening. The strobes are synchronous pulses sampled on the same clock. The direction follows the active-low output enable: when it is asserted the block sends, and when it is released the block captures. An end-of-cycle input takes the place of the final step. It moves the last piece, switches to the other buffer and rewinds the piece counter. A width select limits the data to the low four bits.

Top module: `burst_buf`

## Requirements
- R1: After reset the active buffer is 0, the transfer count is 0, the overflow flag is 0, the bus is not driven and every buffer entry reads 0.
- R2: `mdata_oe` is 1 only while `oe_n` is 0 and either `start` is 1 in that cycle or a write burst is live. `start` makes a burst live, and `eoc` ends it at the next edge.
- R3: `mdata_o` shows the piece at the current count in the active buffer, combinationally, so the first piece is on the bus in the same cycle `start` is asserted.
- R4: In clocked mode (`mode`=0), each edge with `rdy`=1 is one step and advances the count by one. The strobes have no effect, and an edge without a step or `eoc` changes neither the count nor the active buffer.
- R5: In strobed mode (`mode`=1), a step is `ostb` while `oe_n`=0 and `istb` while `oe_n`=1. `rdy` has no effect.
- R6: A step or `eoc` with `oe_n`=1 stores `mdata_i` into the active buffer at the current count. With `oe_n`=0, or on an edge with no step, nothing is captured.
- R7: `eoc` counts as the final transfer, even when it coincides with a step (one transfer only). At that edge the active buffer toggles and the count returns to 0.
- R8: With `wide`=0, `mdata_o[7:4]` is 0, and captured pieces are stored with bits 7:4 cleared.
- R9: A step without `eoc` when the count is already 4 sets `ovf_err`. The flag stays set until reset, and that step captures nothing and leaves the count at 4.
- R10: `ld_en` writes `ld_data` into buffer `ld_bank` at entry `ld_idx` on the clock edge. `rd_data` combinationally shows entry `rd_idx` of buffer `rd_bank`. When a load and a bus capture hit the same entry in one cycle, the captured bus data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 clocked (ready), 1 strobed |
| wide | input | 1 | 1 full 8-bit data, 0 low 4 bits only |
| oe_n | input | 1 | Active-low output enable; high means listen |
| start | input | 1 | Data-valid start of a burst |
| rdy | input | 1 | Ready step in clocked mode |
| ostb | input | 1 | Output strobe pulse in strobed mode |
| istb | input | 1 | Input strobe pulse in strobed mode |
| eoc | input | 1 | End of cycle: final transfer and buffer switch |
| mdata_i | input | 8 | Memory bus data seen at the pad |
| mdata_o | output | 8 | Memory bus data to drive |
| mdata_oe | output | 1 | Pad drive enable |
| ld_en | input | 1 | CPU-side load strobe |
| ld_bank | input | 1 | Buffer selected for load |
| ld_idx | input | 2 | Entry selected for load |
| ld_data | input | 8 | Load data |
| rd_bank | input | 1 | Buffer selected for unload |
| rd_idx | input | 2 | Entry selected for unload |
| rd_data | output | 8 | Unload data |
| act_bank | output | 1 | Buffer currently on the memory bus |
| pieces | output | 3 | Pieces transferred in the current burst (0 to 4) |
| ovf_err | output | 1 | Sticky overflow flag |

## Verification
A CPU-side load and a bus capture can target the same entry of the active buffer in one cycle. That happens when the CPU refills the buffer while a read burst is still landing. The bench forces this case in a directed step: it loads the entry under the current count while a ready or input strobe arrives with the output enable released. It also lets the collision happen freely in random traffic. The result is judged by unloading that entry afterwards and expecting the bus value rather than the load value. A second pairing, `eoc` together with a step, is checked to count as a single transfer.

// File: rtl/burst_buf_pkg.sv
package burst_buf_pkg;
  typedef enum logic {
    MODE_CLOCKED = 1'b0,
    MODE_STROBED = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/burst_buf_ctrl.sv
module burst_buf_ctrl #(
  parameter  int DEPTH = 4,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          oe_n,
  input  logic          start,
  input  logic          rdy,
  input  logic          ostb,
  input  logic          istb,
  input  logic          eoc,
  output logic          act,
  output logic [CW-1:0] cnt,
  output logic [PW-1:0] idx,
  output logic          err,
  output logic          drive,
  output logic          cap_en
);
  import burst_buf_pkg::*;

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  function automatic logic pick_step(xfer_mode_e m, logic listen,
                                     logic r, logic os, logic is);
    if (m == MODE_CLOCKED) return r;
    return listen ? is : os;
  endfunction

  function automatic logic [CW-1:0] count_next(logic [CW-1:0] c,
                                               logic mv, logic sw);
    if (sw) return '0;
    if (mv) return c + 1'b1;
    return c;
  endfunction

  xfer_mode_e mode_e;
  logic step, xfer, ovf_hit, live;

  assign mode_e  = xfer_mode_e'(mode);
  assign step    = pick_step(mode_e, oe_n, rdy, ostb, istb);
  assign xfer    = (step | eoc) & (cnt < FULL);
  assign ovf_hit = step & ~eoc & (cnt == FULL);
  assign cap_en  = xfer & oe_n;
  assign drive   = ~oe_n & (start | live);
  assign idx     = cnt[PW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= 1'b0;
      cnt  <= '0;
      err  <= 1'b0;
      live <= 1'b0;
    end else begin
      cnt <= count_next(cnt, xfer, eoc);
      if (eoc) act <= ~act;
      if (ovf_hit) err <= 1'b1;
      if (eoc) live <= 1'b0;
      else if (start) live <= 1'b1;
    end
  end

  p_swap_on_eoc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> (act != $past(act)) && (cnt == '0));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !eoc) |=> ($stable(cnt) && $stable(act)));

  p_live_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> (!drive || start));
endmodule

// File: rtl/burst_buf_store.sv
module burst_buf_store #(
  parameter  int DW    = 8,
  parameter  int NW    = 4,
  parameter  int DEPTH = 4,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          ld_en,
  input  logic          ld_bank,
  input  logic [PW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic          cap_en,
  input  logic          act,
  input  logic [PW-1:0] idx,
  input  logic [DW-1:0] bus_in,
  input  logic          rd_bank,
  input  logic [PW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] piece_out
);
  logic [DW-1:0] mem [2][DEPTH];
  logic [DW-1:0] cap_val, raw_piece;

  function automatic logic [DW-1:0] fit(logic [DW-1:0] d, logic w);
    logic [DW-1:0] m;
    m = {{(DW-NW){1'b0}}, {NW{1'b1}}};
    return w ? d : (d & m);
  endfunction

  generate
    if (NW < DW) begin : g_narrow
      assign cap_val   = fit(bus_in, wide);
      assign piece_out = fit(raw_piece, wide);
    end else begin : g_full
      assign cap_val   = bus_in;
      assign piece_out = raw_piece;
    end
  endgenerate

  assign raw_piece = mem[act][idx];
  assign rd_data   = mem[rd_bank][rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int e = 0; e < DEPTH; e++)
          mem[b][e] <= '0;
    end else begin
      if (ld_en) mem[ld_bank][ld_idx] <= ld_data;
      if (cap_en) mem[act][idx] <= cap_val;
    end
  end
endmodule

// File: rtl/burst_buf.sv
module burst_buf #(
  parameter  int DW    = 8,
  parameter  int NW    = 4,
  parameter  int DEPTH = 4,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          wide,
  input  logic          oe_n,
  input  logic          start,
  input  logic          rdy,
  input  logic          ostb,
  input  logic          istb,
  input  logic          eoc,
  input  logic [DW-1:0] mdata_i,
  output logic [DW-1:0] mdata_o,
  output logic          mdata_oe,
  input  logic          ld_en,
  input  logic          ld_bank,
  input  logic [PW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic          rd_bank,
  input  logic [PW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          act_bank,
  output logic [CW-1:0] pieces,
  output logic          ovf_err
);
  logic          cap_en;
  logic [PW-1:0] idx;

  burst_buf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .oe_n(oe_n), .start(start),
    .rdy(rdy), .ostb(ostb), .istb(istb), .eoc(eoc),
    .act(act_bank), .cnt(pieces), .idx(idx), .err(ovf_err),
    .drive(mdata_oe), .cap_en(cap_en)
  );

  burst_buf_store #(.DW(DW), .NW(NW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wide(wide),
    .ld_en(ld_en), .ld_bank(ld_bank), .ld_idx(ld_idx), .ld_data(ld_data),
    .cap_en(cap_en), .act(act_bank), .idx(idx), .bus_in(mdata_i),
    .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data),
    .piece_out(mdata_o)
  );

  p_capture_listens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> oe_n);

  p_narrow_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (mdata_o[DW-1:NW] == '0));

  p_count_moves_by_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |=> (pieces == $past(pieces)) || (pieces == $past(pieces) + 1'b1));
endmodule

// File: tb/burst_buf_test.sv
module burst_buf_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic mode, wide, oe_n, start, rdy, ostb, istb, eoc;
  logic [7:0] mdata_i, mdata_o, ld_data, rd_data;
  logic mdata_oe, ld_en, ld_bank, rd_bank, act_bank, ovf_err;
  logic [1:0] ld_idx, rd_idx;
  logic [2:0] pieces;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] mb [2][4];
  logic       m_act, m_err, m_live;
  logic [2:0] m_cnt;

  always #(PERIOD/2) clk = ~clk;

  burst_buf uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wide(wide), .oe_n(oe_n),
    .start(start), .rdy(rdy), .ostb(ostb), .istb(istb), .eoc(eoc),
    .mdata_i(mdata_i), .mdata_o(mdata_o), .mdata_oe(mdata_oe),
    .ld_en(ld_en), .ld_bank(ld_bank), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data),
    .act_bank(act_bank), .pieces(pieces), .ovf_err(ovf_err)
  );

  function automatic logic [7:0] trim(logic [7:0] d, logic w);
    return w ? d : {4'h0, d[3:0]};
  endfunction

  function automatic logic is_step(logic m, logic listen, logic r,
                                   logic os, logic is);
    if (m) return listen ? is : os;
    return r;
  endfunction

  task automatic cmp(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 2; b++)
      for (int e = 0; e < 4; e++) mb[b][e] = 8'h00;
    m_act = 0; m_err = 0; m_live = 0; m_cnt = 0;
  endtask

  task automatic idle_inputs();
    start = 0; rdy = 0; ostb = 0; istb = 0; eoc = 0; ld_en = 0;
  endtask

  task automatic check_all();
    logic [7:0] piece;
    piece = trim(mb[m_act][m_cnt[1:0]], wide);
    cmp(wide ? "R3" : "R8", mdata_o, piece);
    cmp("R2", {7'b0, mdata_oe}, {7'b0, (!oe_n && (start || m_live))});
    cmp("R7", {7'b0, act_bank}, {7'b0, m_act});
    cmp(mode ? "R5" : "R4", {5'b0, pieces}, {5'b0, m_cnt});
    cmp("R9", {7'b0, ovf_err}, {7'b0, m_err});
    cmp(oe_n ? "R6" : "R10", rd_data, mb[rd_bank][rd_idx]);
  endtask

  task automatic model_edge();
    logic st, xf;
    st = is_step(mode, oe_n, rdy, ostb, istb);
    xf = (st || eoc) && (m_cnt < 3'd4);
    if (ld_en) mb[ld_bank][ld_idx] = ld_data;
    if (xf && oe_n) mb[m_act][m_cnt[1:0]] = trim(mdata_i, wide);
    if (st && !eoc && m_cnt == 3'd4) m_err = 1;
    if (eoc) m_live = 0; else if (start) m_live = 1;
    if (eoc) begin m_act = ~m_act; m_cnt = 0; end
    else if (xf) m_cnt = m_cnt + 1;
  endtask

  task automatic tick();
    #1 check_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    logic [7:0] r;
    seed = 32'h5A17;
    r = 8'($urandom(seed));
    idle_inputs();
    mode = 0; wide = 1; oe_n = 1; mdata_i = 0;
    ld_bank = 0; ld_idx = 0; ld_data = 0; rd_bank = 0; rd_idx = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state at the ports
    #1;
    cmp("R1", {5'b0, act_bank, pieces, ovf_err}, 8'h00);
    cmp("R1", {7'b0, mdata_oe}, 8'h00);
    for (int e = 0; e < 4; e++) begin
      rd_bank = 1; rd_idx = 2'(e); #1;
      cmp("R1", rd_data, 8'h00);
    end
    @(negedge clk);

    // R10: CPU fills buffer 0
    for (int e = 0; e < 4; e++) begin
      ld_en = 1; ld_bank = 0; ld_idx = 2'(e); ld_data = 8'hA0 + 8'(e);
      tick();
    end
    idle_inputs();

    // R3/R4/R7: clocked write burst, eoc replaces last ready
    oe_n = 0; mode = 0; start = 1; tick();
    start = 0; rdy = 1; tick(); tick(); tick();
    rdy = 1; eoc = 1; tick();
    idle_inputs(); oe_n = 1; tick();

    // R5/R6: strobed read into buffer 1, rdy ignored
    mode = 1;
    for (int e = 0; e < 3; e++) begin
      istb = 1; rdy = 1; mdata_i = 8'h5C + 8'(e); tick();
      istb = 0; rdy = 1; mdata_i = 8'hFF; tick();
    end
    eoc = 1; mdata_i = 8'h3E; tick();
    idle_inputs();
    for (int e = 0; e < 4; e++) begin
      rd_bank = 1; rd_idx = 2'(e); tick();
    end

    // R8: narrow read in clocked mode
    mode = 0; wide = 0; rdy = 1; mdata_i = 8'hB7; tick();
    idle_inputs(); rd_bank = 0; rd_idx = 0; tick();
    wide = 1;

    // R10: load and capture on the same entry, capture kept
    ld_en = 1; ld_bank = act_bank; ld_idx = pieces[1:0]; ld_data = 8'h11;
    rd_bank = act_bank; rd_idx = pieces[1:0];
    rdy = 1; mdata_i = 8'hC9; tick();
    idle_inputs(); tick();

    // R9: step past four pieces without eoc
    rdy = 1; mdata_i = 8'h42;
    repeat (5) tick();
    idle_inputs(); tick(); tick();

    // constrained random traffic
    rst_n = 0; model_reset(); @(negedge clk); rst_n = 1;
    for (int i = 0; i < 3000; i++) begin
      mode    = ($urandom % 4) == 0;
      wide    = ($urandom % 3) != 0;
      oe_n    = 1'($urandom);
      start   = ($urandom % 6) == 0;
      rdy     = ($urandom % 2) == 0;
      ostb    = ($urandom % 3) == 0;
      istb    = ($urandom % 3) == 0;
      eoc     = ($urandom % 5) == 0;
      mdata_i = 8'($urandom);
      ld_en   = ($urandom % 3) == 0;
      ld_bank = 1'($urandom);
      ld_idx  = 2'($urandom);
      ld_data = 8'($urandom);
      rd_bank = 1'($urandom);
      rd_idx  = 2'($urandom);
      tick();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule